// File: doc/BRIEF.md
# SRAM Bus Turnaround Command Scheduler

This block drives the command pins of a burst-of-two DDR SRAM that has on-die termination on its data lines. Requests arrive from a queue through a ready/valid handshake. Each cycle the block issues exactly one command: a Read, a Write, a read-flavoured idle or a write-flavoured idle. Each Read or Write moves two data beats within one clock cycle. Switching from writes to reads costs nothing. Switching from reads to writes inserts a run of read-flavoured idles, then a run of write-flavoured idles, before the Write goes out. While those idles are issued, the requester is stalled.

The two idle counts come from configuration inputs. They are clamped up to fixed minimums of 4 read-flavoured and 3 write-flavoured idles, and they are held in registers that do not change while a turnaround is in progress. The block also produces, aligned with each command, the controller's DQ termination enable and its DQ drive-low enable. Termination is switched on around the boundary between the two idle runs: during the last `lead` read-flavoured idles and the first `lag` write-flavoured idles. Both offsets are configuration inputs. Drive-low is active whenever termination is off and no write data is on the bus.

Top module: `turnaround_sched`

## Requirements
- R1: During and after reset, until the first request, the command output is the write-flavoured idle, termination is off, drive-low is on and req_ready is high. The command codes are 0 = read idle, 1 = write idle, 2 = Read and 3 = Write.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) appears on cmd_code in the next cycle, as Read (2) or Write (3), with its address on cmd_addr. Idle commands carry address 0.
- R3: A read accepted in the cycle after a Write is issued at once, with no idle cycles between the two commands.
- R4: A write that follows reads is preceded by exactly N_r read idles and then exactly N_w write idles. req_ready stays low until the cycle in which the Write is accepted.
- R5: The effective N_r is the larger of cfg_rd_nops and 4. The effective N_w is the larger of cfg_wr_nops and 3.
- R6: When no request is valid, the idle issued is a read idle if the last Read or Write was a Read, and a write idle otherwise.
- R7: term_en is high on read idle k of a turnaround when k + lead > N_r, and on write idle k when k <= lag. It is low in every other cycle.
- R8: drive_low is high exactly when term_en is low and the command is not a Write.
- R9: The effective lead is the smaller of cfg_term_lead and N_r. The effective lag is the smaller of cfg_term_lag and N_w.
- R10: Changes to the configuration inputs during a turnaround have no effect on that turnaround. The new values take effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| cfg_rd_nops | input | CNT_W | Requested number of read idles after reads |
| cfg_wr_nops | input | CNT_W | Requested number of write idles before a write |
| cfg_term_lead | input | CNT_W | Number of read idles, counted back from the end of the run, that have termination on |
| cfg_term_lag | input | CNT_W | Number of leading write idles that have termination on |
| cmd_code | output | 2 | Command issued this cycle |
| cmd_addr | output | ADDR_W | Address of the command issued this cycle |
| term_en | output | 1 | Controller DQ termination enable |
| drive_low | output | 1 | Controller drives DQ low |

## Verification
The checker assumes that the requester keeps req_valid, req_write and req_addr steady from the moment it raises a request until the request is accepted. The idle-count properties depend on this, because a write request that is withdrawn halfway through a turnaround would still leave the direction state consistent, but it would no longer match a real pending write. The bench changes request inputs only in the cycle right after an accepted handshake, and it moves the configuration inputs mid-turnaround only in the one scenario built to show that they are ignored there.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        CMD_NOPR = 2'd0,
        CMD_NOPW = 2'd1,
        CMD_RD   = 2'd2,
        CMD_WR   = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RDIR = 2'd0,
        ST_RNOP = 2'd1,
        ST_WNOP = 2'd2,
        ST_WDIR = 2'd3
    } state_e;

endpackage

// File: rtl/sched_cfg.sv
module sched_cfg #(
    parameter int CNT_W    = 4,
    parameter int MIN_RD   = 4,
    parameter int MIN_WR   = 3,
    parameter int DEF_RD   = 6,
    parameter int DEF_WR   = 5,
    parameter int DEF_LEAD = 2,
    parameter int DEF_LAG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] raw_rd,
    input  logic [CNT_W-1:0] raw_wr,
    input  logic [CNT_W-1:0] raw_lead,
    input  logic [CNT_W-1:0] raw_lag,
    output logic [CNT_W-1:0] rd_n,
    output logic [CNT_W-1:0] wr_n,
    output logic [CNT_W-1:0] lead,
    output logic [CNT_W-1:0] lag
);

    localparam logic [CNT_W-1:0] MIN_RD_V = CNT_W'(MIN_RD);
    localparam logic [CNT_W-1:0] MIN_WR_V = CNT_W'(MIN_WR);

    logic [CNT_W-1:0] rd_c, wr_c, lead_c, lag_c;

    // Idle counts are raised to their floors; the termination offsets
    // are then capped by the idle runs they refer to.
    always_comb begin
        rd_c   = (raw_rd < MIN_RD_V) ? MIN_RD_V : raw_rd;
        wr_c   = (raw_wr < MIN_WR_V) ? MIN_WR_V : raw_wr;
        lead_c = (raw_lead > rd_c) ? rd_c : raw_lead;
        lag_c  = (raw_lag > wr_c) ? wr_c : raw_lag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n <= CNT_W'(DEF_RD);
            wr_n <= CNT_W'(DEF_WR);
            lead <= CNT_W'(DEF_LEAD);
            lag  <= CNT_W'(DEF_LAG);
        end else if (!hold) begin
            rd_n <= rd_c;
            wr_n <= wr_c;
            lead <= lead_c;
            lag  <= lag_c;
        end
    end

endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
    import sched_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  rd_n,
    input  logic [CNT_W-1:0]  wr_n,
    input  logic [CNT_W-1:0]  lead,
    input  logic [CNT_W-1:0]  lag,
    output logic              req_ready,
    output logic              hold,
    output logic [1:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              term_en,
    output logic              drive_low
);

    localparam int KW = CNT_W + 1;

    state_e            state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    cmd_e              cmd_q, cmd_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              term_q, term_n;
    logic              dl_q, dl_n;
    logic [KW-1:0]     k_next;

    assign k_next = KW'(cnt) + KW'(1);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WDIR;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state, handshake and the command chosen for the next cycle.
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        cmd_n     = CMD_NOPW;
        addr_n    = '0;
        term_n    = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_WDIR: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    addr_n = req_addr;
                    if (req_write) begin
                        cmd_n = CMD_WR;
                    end else begin
                        cmd_n   = CMD_RD;
                        state_n = ST_RDIR;
                    end
                end
            end
            ST_RDIR: begin
                req_ready = !req_write;
                cmd_n     = CMD_NOPR;
                if (req_valid && !req_write) begin
                    cmd_n  = CMD_RD;
                    addr_n = req_addr;
                end else if (req_valid) begin
                    state_n = ST_RNOP;
                    cnt_n   = CNT_W'(1);
                    term_n  = (KW'(1) + KW'(lead)) > KW'(rd_n);
                end
            end
            ST_RNOP: begin
                if (cnt < rd_n) begin
                    cmd_n  = CMD_NOPR;
                    cnt_n  = cnt + CNT_W'(1);
                    term_n = (k_next + KW'(lead)) > KW'(rd_n);
                end else begin
                    cmd_n   = CMD_NOPW;
                    state_n = ST_WNOP;
                    cnt_n   = CNT_W'(1);
                    term_n  = (lag != '0);
                end
            end
            ST_WNOP: begin
                if (cnt < wr_n) begin
                    cmd_n  = CMD_NOPW;
                    cnt_n  = cnt + CNT_W'(1);
                    term_n = k_next <= KW'(lag);
                end else begin
                    req_ready = 1'b1;
                    state_n   = ST_WDIR;
                    if (req_valid) begin
                        addr_n = req_addr;
                        if (req_write) begin
                            cmd_n = CMD_WR;
                        end else begin
                            cmd_n   = CMD_RD;
                            state_n = ST_RDIR;
                        end
                    end
                end
            end
        endcase
        dl_n = !term_n && (cmd_n != CMD_WR);
    end

    // Registered command-pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOPW;
            addr_q <= '0;
            term_q <= 1'b0;
            dl_q   <= 1'b1;
        end else begin
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            term_q <= term_n;
            dl_q   <= dl_n;
        end
    end

    assign hold      = (state == ST_RNOP) || (state == ST_WNOP);
    assign cmd_code  = cmd_q;
    assign cmd_addr  = addr_q;
    assign term_en   = term_q;
    assign drive_low = dl_q;

endmodule

// File: rtl/turnaround_sched.sv
module turnaround_sched #(
    parameter int ADDR_W        = 20,
    parameter int CNT_W         = 4,
    parameter int MIN_RD_NOPS   = 4,
    parameter int MIN_WR_NOPS   = 3,
    parameter int DEF_RD_NOPS   = 6,
    parameter int DEF_WR_NOPS   = 5,
    parameter int DEF_TERM_LEAD = 2,
    parameter int DEF_TERM_LAG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  cfg_rd_nops,
    input  logic [CNT_W-1:0]  cfg_wr_nops,
    input  logic [CNT_W-1:0]  cfg_term_lead,
    input  logic [CNT_W-1:0]  cfg_term_lag,
    output logic [1:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              term_en,
    output logic              drive_low
);

    logic             hold;
    logic [CNT_W-1:0] rd_n, wr_n, lead, lag;

    sched_cfg #(
        .CNT_W   (CNT_W),
        .MIN_RD  (MIN_RD_NOPS),
        .MIN_WR  (MIN_WR_NOPS),
        .DEF_RD  (DEF_RD_NOPS),
        .DEF_WR  (DEF_WR_NOPS),
        .DEF_LEAD(DEF_TERM_LEAD),
        .DEF_LAG (DEF_TERM_LAG)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .raw_rd  (cfg_rd_nops),
        .raw_wr  (cfg_wr_nops),
        .raw_lead(cfg_term_lead),
        .raw_lag (cfg_term_lag),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .lead    (lead),
        .lag     (lag)
    );

    sched_fsm #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .lead     (lead),
        .lag      (lag),
        .req_ready(req_ready),
        .hold     (hold),
        .cmd_code (cmd_code),
        .cmd_addr (cmd_addr),
        .term_en  (term_en),
        .drive_low(drive_low)
    );

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int MIN_RD = 4,
    parameter int MIN_WR = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [1:0] cmd_code,
    input logic       term_en,
    input logic       drive_low
);

    localparam int RUN_W = 8;
    localparam logic [1:0] C_NOPR = 2'd0;
    localparam logic [1:0] C_NOPW = 2'd1;
    localparam logic [1:0] C_RD   = 2'd2;
    localparam logic [1:0] C_WR   = 2'd3;

    logic [RUN_W-1:0] rrun, wrun;
    logic             rd_since_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrun        <= '0;
            wrun        <= '0;
            rd_since_wr <= 1'b0;
        end else begin
            rrun <= (cmd_code != C_NOPR) ? '0 : ((&rrun) ? rrun : rrun + 1'b1);
            wrun <= (cmd_code != C_NOPW) ? '0 : ((&wrun) ? wrun : wrun + 1'b1);
            if (cmd_code == C_RD)      rd_since_wr <= 1'b1;
            else if (cmd_code == C_WR) rd_since_wr <= 1'b0;
        end
    end

    a_r2_read_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (cmd_code == C_RD));

    a_r2_write_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (cmd_code == C_WR));

    a_r4_read_idle_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_NOPW && rrun != '0) |-> (rrun >= RUN_W'(MIN_RD)));

    a_r4_write_idle_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_WR && rd_since_wr) |-> (wrun >= RUN_W'(MIN_WR)));

    a_r6_idle_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_RD && !req_valid) |=> (cmd_code == C_NOPR));

    a_r6_idle_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_WR && !req_valid) |=> (cmd_code == C_NOPW));

    a_r7_term_only_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        term_en |-> (cmd_code == C_NOPR || cmd_code == C_NOPW));

    a_r8_no_low_with_term: assert property (@(posedge clk) disable iff (!rst_n)
        term_en |-> !drive_low);

    a_r8_write_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == C_WR) |-> (!drive_low && !term_en));

endmodule

bind turnaround_sched sched_chk #(
    .MIN_RD(MIN_RD_NOPS),
    .MIN_WR(MIN_WR_NOPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .cmd_code (cmd_code),
    .term_en  (term_en),
    .drive_low(drive_low)
);

// File: tb/turnaround_sched_test.sv
`timescale 1ns/1ps
module turnaround_sched_test;

    localparam int AW = 20;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] cfg_rd_nops = 4'd6;
    logic [CW-1:0] cfg_wr_nops = 4'd5;
    logic [CW-1:0] cfg_term_lead = 4'd2;
    logic [CW-1:0] cfg_term_lag = 4'd2;
    logic [1:0]    cmd_code;
    logic [AW-1:0] cmd_addr;
    logic          term_en;
    logic          drive_low;

    always #2 clk = ~clk;

    turnaround_sched uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr),
        .cfg_rd_nops(cfg_rd_nops), .cfg_wr_nops(cfg_wr_nops),
        .cfg_term_lead(cfg_term_lead), .cfg_term_lag(cfg_term_lag),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .term_en(term_en), .drive_low(drive_low)
    );

    typedef struct {
        logic [1:0]    cmd;
        logic [AW-1:0] addr;
        logic          term;
        logic          dl;
        string         rq;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   m_rd = 6, m_wr = 5, m_lead = 2, m_lag = 2;
    bit   m_dir_rd = 1'b0;

    task automatic check(bit ok, string rq, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic push(logic [1:0] c, logic [AW-1:0] a, logic t, string rq);
        exp_t e;
        e.cmd = c; e.addr = a; e.term = t;
        e.dl = !t && (c != 2'd3);
        e.rq = rq;
        q.push_back(e);
    endtask

    // Monitor: compares every produced command with the scoreboard head.
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(cmd_code == e.cmd, e.rq, "cmd_code", int'(cmd_code), int'(e.cmd));
            check(cmd_addr == e.addr, e.rq, "cmd_addr", int'(cmd_addr), int'(e.addr));
            check(term_en == e.term, e.rq, "term_en", int'(term_en), int'(e.term));
            check(drive_low == e.dl, "R8", "drive_low", int'(drive_low), int'(e.dl));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            push(m_dir_rd ? 2'd0 : 2'd1, '0, 1'b0, "R6");
        end
    endtask

    // R5 and R9: the clamps computed by the bench model.
    task automatic set_cfg(int r, int w, int ld, int lg);
        @(negedge clk);
        req_valid = 1'b0;
        push(m_dir_rd ? 2'd0 : 2'd1, '0, 1'b0, "R6");
        cfg_rd_nops = CW'(r); cfg_wr_nops = CW'(w);
        cfg_term_lead = CW'(ld); cfg_term_lag = CW'(lg);
        m_rd   = (r < 4) ? 4 : r;
        m_wr   = (w < 3) ? 3 : w;
        m_lead = (ld > m_rd) ? m_rd : ld;
        m_lag  = (lg > m_wr) ? m_wr : lg;
        idle(2);
    endtask

    task automatic issue(bit wr, logic [AW-1:0] a, string rq, bit poke_cfg);
        if (wr && m_dir_rd) begin
            for (int k = 1; k <= m_rd; k++) begin
                @(negedge clk);
                req_valid = 1'b1; req_write = 1'b1; req_addr = a;
                if (poke_cfg && k == 3) begin
                    cfg_rd_nops = 4'd9; cfg_wr_nops = 4'd9;
                    cfg_term_lead = 4'd3; cfg_term_lag = 4'd3;
                end
                push(2'd0, '0, (k + m_lead) > m_rd, poke_cfg ? "R10" : "R7");
                #1 check(req_ready == 1'b0, "R4", "req_ready in read idles", int'(req_ready), 0);
            end
            for (int k = 1; k <= m_wr; k++) begin
                @(negedge clk);
                push(2'd1, '0, k <= m_lag, poke_cfg ? "R10" : "R7");
                #1 check(req_ready == 1'b0, "R4", "req_ready in write idles", int'(req_ready), 0);
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        push(wr ? 2'd3 : 2'd2, a, 1'b0, rq);
        #1 check(req_ready == 1'b1, rq, "req_ready at accept", int'(req_ready), 1);
        m_dir_rd = !wr;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cmd_code == 2'd1, "R1", "cmd_code after reset", int'(cmd_code), 1);
        check(term_en == 1'b0, "R1", "term_en after reset", int'(term_en), 0);
        check(drive_low == 1'b1, "R1", "drive_low after reset", int'(drive_low), 1);
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

        idle(2);
        issue(1'b1, 20'h00011, "R2", 1'b0);
        issue(1'b1, 20'h00022, "R2", 1'b0);
        issue(1'b0, 20'h00033, "R3", 1'b0);
        issue(1'b0, 20'h00044, "R2", 1'b0);
        idle(3);
        issue(1'b1, 20'h00055, "R4", 1'b0);
        idle(2);
        issue(1'b0, 20'h00066, "R3", 1'b0);
        issue(1'b1, 20'h00077, "R4", 1'b0);

        set_cfg(1, 0, 2, 2);
        issue(1'b0, 20'h00101, "R2", 1'b0);
        issue(1'b1, 20'h00102, "R5", 1'b0);

        set_cfg(7, 4, 9, 9);
        issue(1'b0, 20'h00201, "R2", 1'b0);
        issue(1'b1, 20'h00202, "R9", 1'b0);

        set_cfg(5, 4, 0, 0);
        issue(1'b0, 20'h00301, "R2", 1'b0);
        issue(1'b1, 20'h00302, "R7", 1'b0);

        set_cfg(6, 5, 2, 2);
        issue(1'b0, 20'h00401, "R2", 1'b0);
        issue(1'b1, 20'h00402, "R10", 1'b1);
        set_cfg(9, 9, 3, 3);
        issue(1'b0, 20'h00501, "R2", 1'b0);
        issue(1'b1, 20'h00502, "R10", 1'b0);
        idle(2);

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2", "scoreboard leftover", q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule